// File: doc/BRIEF.md
# Scanline Interrupt Counter with Post-Fire Lockout

This block raises a raster interrupt after a programmed number of displayed lines. A line-event pulse comes with the number of the line that has just started and a flag that says whether rendering is on. The CPU sets up the counter through four write-only registers. They sit in the upper CPU address space and are decoded on the top three address bits and address bit 0. One register loads the counter directly, one sets the reload value, one switches the interrupt off and clears it, and one switches it on.

On every line that is evaluated, the counter is decremented. When it is found at zero it is loaded from the reload value and the interrupt is raised. The decrement of that line is then applied as well. After it fires, the block locks itself: no further line changes the counter until the CPU writes any of the four registers. On line 0 a nonzero counter loses one extra count before the zero test. The interrupt is a level output. It stays high until the CPU writes the disable register.

Top module: `scanirq_top`

## Requirements
- R1: After a synchronous reset the counter, reload value, enable and lockout are all zero and `irq` is low. The first evaluated line after enabling therefore fires at once.
- R2: A write is decoded on address bits [15:13] and bit 0 only. 110/0 loads the counter, 110/1 loads the reload value, 111/0 clears the enable and drops `irq`, and 111/1 sets the enable. Aliases such as 0xDFFE (counter) and 0xFFFF (enable) act the same way. Writes with bits [15:13] below 110 change nothing.
- R3: A write to any of the four registers clears the lockout.
- R4: A line event is evaluated only when the line number is 0 to 239, `render_en` is high, the enable is set and the lockout is clear. Any other line event leaves the counter and `irq` unchanged.
- R5: On an evaluated line 0, a nonzero counter is decremented once before the zero test. A counter of 2 therefore reaches zero without firing, and a counter of 1 fires on line 0.
- R6: When the counter is zero at the test, the block sets the lockout, loads the counter from the reload value and raises `irq`. A counter loaded with k (nonzero, no line 0 involved) fires on the (k+1)-th evaluated line.
- R7: After the test, every evaluated line decrements the counter modulo 256. A reload value of 0 leaves 255 after firing, so the next interrupt comes on the 256th evaluated line.
- R8: `irq` stays high through idle cycles, line events and writes other than the disable write, until that write or reset.
- R9: While the lockout is set, line events do not change the counter. After the CPU unlocks, counting resumes from the value that was loaded at the fire.
- R10: When a register write and a line event occur in the same cycle, the write is applied and the line event is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| line_pulse | input | 1 | One-cycle line event |
| line_num | input | 9 | Number of the line that just started |
| render_en | input | 1 | Rendering is enabled |
| irq | output | 1 | Level interrupt request |

## Verification
The counter cannot be seen from outside, so every scenario measures how many line events pass until `irq` rises and compares that number with the one derived from the requirements. Loads of 3, 1, 2 and 0, and reload values of 9 and 0, tell a correct count apart from an off-by-one error and from a missing wrap. Line-0 events with counters of 2 and 1 tell the extra decrement apart from a plain one. Events that should be ignored are placed before a short count: out-of-range lines, rendering off, the block disabled, a locked block, and a line that collides with a write. If any of them were counted, the interrupt would come one line early, or, for the locked case, several lines early.

// File: rtl/scanirq_pkg.sv
package scanirq_pkg;

    // Register selected by a CPU write
    typedef enum logic [2:0] {
        REG_NONE  = 3'd0,
        REG_COUNT = 3'd1,
        REG_RELOAD = 3'd2,
        REG_OFF   = 3'd3,
        REG_ON    = 3'd4
    } reg_sel_e;

    // Control flags held by the block
    typedef struct packed {
        logic en;
        logic lock;
        logic irq;
    } ctl_t;

    localparam logic [2:0] PAGE_COUNTER = 3'b110;
    localparam logic [2:0] PAGE_ENABLE  = 3'b111;

    // Decode from the top three address bits and the lowest one
    function automatic reg_sel_e sel_of(input logic [2:0] page, input logic odd);
        reg_sel_e s;
        s = REG_NONE;
        if (page == PAGE_COUNTER)
            s = odd ? REG_RELOAD : REG_COUNT;
        else if (page == PAGE_ENABLE)
            s = odd ? REG_ON : REG_OFF;
        return s;
    endfunction

endpackage

// File: rtl/scanirq_regdec.sv
module scanirq_regdec
    import scanirq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output reg_sel_e          wr_sel
);
    localparam int PAGE_LSB = ADDR_W - 3;

    logic [2:0] page;
    logic       unused_mid;

    assign page       = wr_addr[ADDR_W-1:PAGE_LSB];
    assign unused_mid = ^wr_addr[PAGE_LSB-1:1];

    always_comb begin
        wr_sel = REG_NONE;
        if (wr_en)
            wr_sel = sel_of(page, wr_addr[0]);
    end
endmodule

// File: rtl/scanirq_eval.sv
module scanirq_eval
    import scanirq_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int LINE_W    = 9,
    parameter int LAST_LINE = 239
) (
    input  logic              line_pulse,
    input  logic [LINE_W-1:0] line_num,
    input  logic              render_en,
    input  ctl_t              ctl,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CNT_W-1:0]  reload,
    output logic              active,
    output logic              fire,
    output logic [CNT_W-1:0]  cnt_next
);
    localparam logic [LINE_W-1:0] LAST = LINE_W'(LAST_LINE);
    localparam logic [CNT_W-1:0]  ONE  = CNT_W'(1);

    logic             top_line;
    logic [CNT_W-1:0] pre_cnt;
    logic [CNT_W-1:0] post_cnt;
    logic             at_zero;

    assign top_line = (line_num == '0);
    assign active   = line_pulse && (line_num <= LAST) && render_en
                      && ctl.en && !ctl.lock;

    always_comb begin
        pre_cnt  = (top_line && cnt != '0) ? cnt - ONE : cnt;
        at_zero  = (pre_cnt == '0);
        post_cnt = at_zero ? reload : pre_cnt;
        cnt_next = post_cnt - ONE;
    end

    assign fire = active && at_zero;
endmodule

// File: rtl/scanirq_top.sv
module scanirq_top
    import scanirq_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int LINE_W    = 9,
    parameter int ADDR_W    = 16,
    parameter int LAST_LINE = 239
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              line_pulse,
    input  logic [LINE_W-1:0] line_num,
    input  logic              render_en,
    output logic              irq
);
    reg_sel_e         wr_sel;
    ctl_t             ctl_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload_q;
    logic             line_active;
    logic             line_fire;
    logic [CNT_W-1:0] cnt_next;

    scanirq_regdec #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_sel  (wr_sel)
    );

    scanirq_eval #(
        .CNT_W(CNT_W), .LINE_W(LINE_W), .LAST_LINE(LAST_LINE)
    ) u_eval (
        .line_pulse (line_pulse),
        .line_num   (line_num),
        .render_en  (render_en),
        .ctl        (ctl_q),
        .cnt        (cnt_q),
        .reload     (reload_q),
        .active     (line_active),
        .fire       (line_fire),
        .cnt_next   (cnt_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            reload_q <= '0;
            ctl_q    <= '0;
        end else if (wr_sel != REG_NONE) begin
            ctl_q.lock <= 1'b0;
            unique case (wr_sel)
                REG_COUNT:  cnt_q    <= wr_data;
                REG_RELOAD: reload_q <= wr_data;
                REG_OFF: begin
                    ctl_q.en  <= 1'b0;
                    ctl_q.irq <= 1'b0;
                end
                REG_ON:     ctl_q.en <= 1'b1;
                default: ;
            endcase
        end else if (line_active) begin
            cnt_q <= cnt_next;
            if (line_fire) begin
                ctl_q.lock <= 1'b1;
                ctl_q.irq  <= 1'b1;
            end
        end
    end

    assign irq = ctl_q.irq;
endmodule

// File: rtl/scanirq_chk.sv
module scanirq_chk #(
    parameter int CNT_W     = 8,
    parameter int LINE_W    = 9,
    parameter int LAST_LINE = 239
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_hit,
    input logic              wr_off,
    input logic              line_pulse,
    input logic [LINE_W-1:0] line_num,
    input logic              render_en,
    input logic              lock,
    input logic              fire,
    input logic [CNT_W-1:0]  cnt,
    input logic              irq
);
    // R3
    unlock_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> !lock);

    // R2
    off_drops_irq_chk: assert property (@(posedge clk) disable iff (rst)
        wr_off |=> !irq);

    // R6
    irq_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(fire));

    // R4
    gated_line_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_hit && (!line_pulse || !render_en || line_num > LINE_W'(LAST_LINE)))
        |=> ($stable(cnt) && $stable(irq)));

    // R9
    locked_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (lock && !wr_hit) |=> $stable(cnt));

    // R8
    irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !wr_off) |=> irq);
endmodule

bind scanirq_top scanirq_chk #(
    .CNT_W(CNT_W), .LINE_W(LINE_W), .LAST_LINE(LAST_LINE)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_hit     (wr_sel != scanirq_pkg::REG_NONE),
    .wr_off     (wr_sel == scanirq_pkg::REG_OFF),
    .line_pulse (line_pulse),
    .line_num   (line_num),
    .render_en  (render_en),
    .lock       (ctl_q.lock),
    .fire       (line_fire),
    .cnt        (cnt_q),
    .irq        (irq)
);

// File: tb/tb_scanirq_top.sv
module tb_scanirq_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       line_pulse = 1'b0;
    logic [8:0] line_num = '0;
    logic       render_en = 1'b1;
    logic       irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    scanirq_top dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .line_pulse(line_pulse), .line_num(line_num),
        .render_en(render_en), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // inputs change on the falling edge; results sampled at the next falling edge
    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic line(input int n, input bit rend = 1'b1);
        line_pulse = 1'b1; line_num = 9'(n); render_en = rend;
        @(negedge clk);
        line_pulse = 1'b0; render_en = 1'b1;
    endtask

    // number of line-50 events until irq rises, 0 if not within lim
    task automatic lines_to_fire(input int lim, output int n);
        n = 0;
        for (int i = 1; i <= lim; i++) begin
            line(50);
            if (irq) begin n = i; break; end
        end
    endtask

    task automatic arm(input logic [7:0] cnt);
        wr(16'hE000, 8'h00);
        wr(16'hC000, cnt);
        wr(16'hE001, 8'h00);
    endtask

    task automatic t_reset();
        int n;
        check(irq == 1'b0, "R1 irq low after reset", irq, 0);
        wr(16'hE001, 8'h00);
        lines_to_fire(3, n);
        check(n == 1, "R1 zero counter fires on first line", n, 1);
    endtask

    task automatic t_basic();
        int n;
        wr(16'hC001, 8'd9);
        arm(8'd3);
        check(irq == 1'b0, "R2 disable write drops irq", irq, 0);
        lines_to_fire(10, n);
        check(n == 4, "R6 count 3 fires on 4th line", n, 4);
    endtask

    task automatic t_lock();
        int n;
        for (int i = 0; i < 5; i++) line(50);
        check(irq == 1'b1, "R8 irq held while locked", irq, 1);
        wr(16'hE000, 8'h00);
        check(irq == 1'b0, "R2 off write clears irq", irq, 0);
        wr(16'hE001, 8'h00);
        lines_to_fire(20, n);
        check(n == 9, "R9 R3 reload 9 resumes at 8 after lock", n, 9);
    endtask

    task automatic t_line0();
        int n;
        arm(8'd2);
        line(0);
        check(irq == 1'b0, "R5 line0 count 2 no fire", irq, 0);
        lines_to_fire(5, n);
        check(n == 1, "R5 fires on next line after line0", n, 1);
        arm(8'd1);
        line(0);
        check(irq == 1'b1, "R5 line0 count 1 fires", irq, 1);
    endtask

    task automatic t_gating();
        int n;
        arm(8'd1);
        line(240);
        line(300);
        line(50, 1'b0);
        repeat (3) @(negedge clk);
        lines_to_fire(5, n);
        check(n == 2, "R4 out-of-range and render-off lines ignored", n, 2);
        wr(16'hE000, 8'h00);
        wr(16'hC000, 8'd1);
        for (int i = 0; i < 3; i++) line(50);
        check(irq == 1'b0, "R4 disabled block stays quiet", irq, 0);
        wr(16'hE001, 8'h00);
        lines_to_fire(5, n);
        check(n == 2, "R4 disabled lines not counted", n, 2);
    endtask

    task automatic t_alias();
        int n;
        wr(16'hE000, 8'h00);
        wr(16'hDFFE, 8'd1);
        wr(16'h8000, 8'd0);
        wr(16'hA001, 8'd0);
        wr(16'hBFFE, 8'd0);
        wr(16'hFFFF, 8'h00);
        lines_to_fire(5, n);
        check(n == 2, "R2 aliases decoded, low writes ignored", n, 2);
    endtask

    task automatic t_wrap();
        int n;
        wr(16'hC001, 8'd0);
        arm(8'd0);
        lines_to_fire(2, n);
        check(n == 1, "R6 zero count fires at once", n, 1);
        wr(16'hE000, 8'h00);
        wr(16'hE001, 8'h00);
        lines_to_fire(300, n);
        check(n == 256, "R7 reload 0 wraps to 255", n, 256);
    endtask

    task automatic t_hold();
        repeat (10) @(negedge clk);
        wr(16'hC000, 8'd5);
        wr(16'hC001, 8'd5);
        wr(16'hE001, 8'h00);
        line(50);
        check(irq == 1'b1, "R8 irq holds through other writes", irq, 1);
        wr(16'hE000, 8'h00);
        check(irq == 1'b0, "R8 irq released by off write", irq, 0);
    endtask

    task automatic t_collide();
        int n;
        arm(8'd1);
        wr_en = 1'b1; wr_addr = 16'hC001; wr_data = 8'd7;
        line_pulse = 1'b1; line_num = 9'd50;
        @(negedge clk);
        wr_en = 1'b0; line_pulse = 1'b0;
        check(irq == 1'b0, "R10 no fire on colliding line", irq, 0);
        lines_to_fire(5, n);
        check(n == 2, "R10 colliding line dropped", n, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_lock();
        t_line0();
        t_gating();
        t_alias();
        t_wrap();
        t_hold();
        t_collide();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule